// File: doc/BRIEF.md
# Character Bank Address Translator

This block turns a 13-bit picture-side address (the 8 KiB character window, 0x0000 to 0x1FFF) into a physical character-memory address. It also flags whether that access goes to the internal character RAM or to character ROM. Its inputs are two outer configuration bytes and eight inner 1 KiB bank numbers. The inner bank numbers come from whichever banking personality is active elsewhere in the cartridge logic. This block only consumes them.

Three mapping schemes exist, and they are checked in a fixed priority:

- **RAM mode.** Maps the whole window onto the start of character RAM.
- **Single 8 KiB ROM bank.** Picks one bank from the outer base alone.
- **1 KiB slot mode (the default).** Blends each slot's inner bank with the outer base under a mask of 5, 7 or 8 bits.

The result is registered, so the address and select appear one clock after the inputs are sampled.

Top module: `chr_bank_mapper`

## Requirements
- R1: While `rst_i` is high at a rising edge, `phys_addr_o` becomes 0 and `ram_sel_o` becomes 0, whatever the other inputs are.
- R2: Outside reset, both outputs take the value computed from the inputs sampled at the preceding rising edge. Between edges they hold steady even if the inputs change.
- R3: When `cfg_mode_i` bit 0 is 1, `phys_addr_o` equals `ppu_addr_i` zero-extended and `ram_sel_o` is 1. This holds no matter what the other mode bits, the base or the bank registers are.
- R4: When bit 0 is 0 and bit 6 is 1, `phys_addr_o` is {outer_base[8:3], ppu_addr_i[12:0]}, which selects one 8 KiB ROM bank.
- R5: The 9-bit outer base, in 1 KiB units, is {`cfg_base_i`, 1'b0}.
- R6: The inner mask is 0x1F when `cfg_mode_i` bit 4 is 1. Otherwise it is 0x7F when bit 5 is 1, and 0xFF when neither bit is set. Bit 4 takes priority over bit 5.
- R7: When bits 0 and 6 are both 0:
  - The slot index is `ppu_addr_i`[12:10].
  - The inner bank is `bank_regs_i`[slot*8 +: 8].
  - The bank is (inner AND mask) OR (outer_base AND NOT mask), with the mask zero-extended to 9 bits.
  - `phys_addr_o` is {bank, `ppu_addr_i`[9:0]}.
- R8: `ram_sel_o` is 0 in every mode except RAM mode.
- R9: In the single 8 KiB bank mode, the bank registers and mode bits 4 and 5 have no effect on `phys_addr_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_mode_i | input | 8 | Mode byte (bit 0 RAM, bit 4 small mask, bit 5 mid mask, bit 6 single 8 KiB bank) |
| cfg_base_i | input | 8 | Outer base byte, doubled to form the 1 KiB outer base |
| bank_regs_i | input | 64 | Eight 8-bit inner bank numbers, slot k at bits [8k+7:8k] |
| ppu_addr_i | input | 13 | Picture-side address within the 8 KiB window |
| phys_addr_o | output | 19 | Registered physical character address |
| ram_sel_o | output | 1 | Registered select, 1 for character RAM |

## Verification
The bench targets mode precedence in several ways:

- **RAM-mode priority.** It sets the RAM bit together with the ROM-mode and mask bits. A design that let the single-bank mode win would raise upper address bits and drop `ram_sel_o`.
- **Mask priority.** It sets both mask bits at once. A design that favoured bit 5 would keep two extra inner bits and produce a wrong bank.
- **Outer bit 8.** Slot-mode checks use an all-ones base under all three masks. A design that truncated the outer base to 8 bits would lose address bit 18, even with the full 0xFF mask.
- **Slot and stability coverage.** It walks every slot to catch a wrong slice of the bank vector. It also changes inputs between edges to catch an output that is not registered.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;

  // Mode byte bit positions; software decodes these, so they are fixed.
  localparam int unsigned RAM_BIT        = 0;
  localparam int unsigned MASK_SMALL_BIT = 4;
  localparam int unsigned MASK_MID_BIT   = 5;
  localparam int unsigned WIDE_BIT       = 6;

  // Inner mask widths for the small and middle settings.
  localparam int unsigned SMALL_MASK_BITS = 5;
  localparam int unsigned MID_MASK_BITS   = 7;

  typedef enum logic [1:0] {
    CHR_RAM    = 2'd0,
    CHR_ROM_8K = 2'd1,
    CHR_ROM_1K = 2'd2
  } chr_mode_e;

endpackage

// File: rtl/chr_mode_decode.sv
module chr_mode_decode
  import chr_map_pkg::*;
#(
  parameter int unsigned INNER_W = 8
) (
  input  logic               ram_bit_i,
  input  logic               wide_bit_i,
  input  logic               small_bit_i,
  input  logic               mid_bit_i,
  output chr_mode_e          mode_o,
  output logic [INNER_W-1:0] mask_o
);

  localparam logic [INNER_W-1:0] SMALL_MASK = INNER_W'((1 << SMALL_MASK_BITS) - 1);
  localparam logic [INNER_W-1:0] MID_MASK   = INNER_W'((1 << MID_MASK_BITS) - 1);
  localparam logic [INNER_W-1:0] FULL_MASK  = '1;

  // RAM beats the single-bank mode, which beats slot banking.
  always_comb begin
    if (ram_bit_i)       mode_o = CHR_RAM;
    else if (wide_bit_i) mode_o = CHR_ROM_8K;
    else                 mode_o = CHR_ROM_1K;
  end

  // The small mask takes precedence over the middle one.
  always_comb begin
    if (small_bit_i)    mask_o = SMALL_MASK;
    else if (mid_bit_i) mask_o = MID_MASK;
    else                mask_o = FULL_MASK;
  end

endmodule

// File: rtl/chr_slot_merge.sv
module chr_slot_merge #(
  parameter int unsigned INNER_W = 8,
  parameter int unsigned BANK_W  = 9,
  parameter int unsigned SLOT_W  = 3
) (
  input  logic [(INNER_W << SLOT_W)-1:0] bank_regs_i,
  input  logic [SLOT_W-1:0]              slot_i,
  input  logic [INNER_W-1:0]             mask_i,
  input  logic [BANK_W-1:0]              outer_i,
  output logic [BANK_W-1:0]              bank_o
);

  localparam int unsigned SLOTS = 1 << SLOT_W;
  localparam int unsigned PAD_W = BANK_W - INNER_W;

  logic [INNER_W-1:0] slot_bank [SLOTS];
  logic [INNER_W-1:0] picked;
  logic [BANK_W-1:0]  mask_ext;

  // Split the flat bank vector into one entry per 1 KiB slot.
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot_bank[g] = bank_regs_i[g*INNER_W +: INNER_W];
  end

  assign picked   = slot_bank[slot_i];
  assign mask_ext = {{PAD_W{1'b0}}, mask_i};

  // Inner bits under the mask, outer bits everywhere else.
  assign bank_o = ({{PAD_W{1'b0}}, picked} & mask_ext) | (outer_i & ~mask_ext);

endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
  import chr_map_pkg::*;
#(
  parameter int unsigned OUTER_W = 8,
  parameter int unsigned INNER_W = 8,
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned KB_BITS = 10
) (
  input  logic                                    clk_i,
  input  logic                                    rst_i,
  input  logic [7:0]                              cfg_mode_i,
  input  logic [OUTER_W-1:0]                      cfg_base_i,
  input  logic [(INNER_W << (ADDR_W-KB_BITS))-1:0] bank_regs_i,
  input  logic [ADDR_W-1:0]                       ppu_addr_i,
  output logic [OUTER_W+KB_BITS:0]                phys_addr_o,
  output logic                                    ram_sel_o
);

  localparam int unsigned SLOT_W = ADDR_W - KB_BITS;
  localparam int unsigned BANK_W = OUTER_W + 1;
  localparam int unsigned PHYS_W = BANK_W + KB_BITS;
  localparam int unsigned BIG_W  = BANK_W - SLOT_W;

  chr_mode_e          mode;
  logic [INNER_W-1:0] mask;
  logic [BANK_W-1:0]  outer_base;
  logic [BANK_W-1:0]  slot_bank;
  logic [PHYS_W-1:0]  phys_next;
  logic               ram_next;
  logic               unused_mode_bits;

  assign unused_mode_bits = ^{cfg_mode_i[7], cfg_mode_i[3:1]};

  // Outer base counted in 1 KiB units.
  assign outer_base = {cfg_base_i, 1'b0};

  chr_mode_decode #(
    .INNER_W (INNER_W)
  ) decode_i (
    .ram_bit_i   (cfg_mode_i[RAM_BIT]),
    .wide_bit_i  (cfg_mode_i[WIDE_BIT]),
    .small_bit_i (cfg_mode_i[MASK_SMALL_BIT]),
    .mid_bit_i   (cfg_mode_i[MASK_MID_BIT]),
    .mode_o      (mode),
    .mask_o      (mask)
  );

  chr_slot_merge #(
    .INNER_W (INNER_W),
    .BANK_W  (BANK_W),
    .SLOT_W  (SLOT_W)
  ) merge_i (
    .bank_regs_i (bank_regs_i),
    .slot_i      (ppu_addr_i[ADDR_W-1:KB_BITS]),
    .mask_i      (mask),
    .outer_i     (outer_base),
    .bank_o      (slot_bank)
  );

  always_comb begin
    ram_next = 1'b0;
    unique case (mode)
      CHR_RAM: begin
        phys_next = {{(PHYS_W-ADDR_W){1'b0}}, ppu_addr_i};
        ram_next  = 1'b1;
      end
      CHR_ROM_8K: phys_next = {outer_base[BANK_W-1:SLOT_W], ppu_addr_i};
      default:    phys_next = {slot_bank, ppu_addr_i[KB_BITS-1:0]};
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phys_addr_o <= '0;
      ram_sel_o   <= 1'b0;
    end else begin
      phys_addr_o <= phys_next;
      ram_sel_o   <= ram_next;
    end
  end

  // Set once the previous edge was outside reset.
  logic chk_armed;
  always_ff @(posedge clk_i) begin
    if (rst_i) chk_armed <= 1'b0;
    else       chk_armed <= 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (phys_addr_o == '0 && !ram_sel_o));

  // R3
  ram_mode_sel_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (chk_armed && $past(cfg_mode_i[RAM_BIT])) |-> ram_sel_o);

  // R8
  ram_sel_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ram_sel_o |-> (phys_addr_o[PHYS_W-1:ADDR_W] == '0));

  // R4
  wide_low_bits_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (chk_armed && ($past(cfg_mode_i[RAM_BIT]) || $past(cfg_mode_i[WIDE_BIT])))
      |-> (phys_addr_o[ADDR_W-1:0] == $past(ppu_addr_i)));

  // R2
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    chk_armed |-> (phys_addr_o[KB_BITS-1:0] == $past(ppu_addr_i[KB_BITS-1:0])));

endmodule

// File: tb/chr_bank_mapper_tb.sv
module chr_bank_mapper_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_i = 1'b1;
  logic [7:0]  cfg_mode_i = '0;
  logic [7:0]  cfg_base_i = '0;
  logic [63:0] bank_regs_i = '0;
  logic [12:0] ppu_addr_i = '0;
  logic [18:0] phys_addr_o;
  logic        ram_sel_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  chr_bank_mapper dut_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .cfg_mode_i  (cfg_mode_i),
    .cfg_base_i  (cfg_base_i),
    .bank_regs_i (bank_regs_i),
    .ppu_addr_i  (ppu_addr_i),
    .phys_addr_o (phys_addr_o),
    .ram_sel_o   (ram_sel_o)
  );

  function automatic logic [18:0] exp_addr(input logic [7:0] m, input logic [7:0] b,
                                           input logic [63:0] regs, input logic [12:0] a);
    logic [8:0] outer;
    logic [8:0] mk;
    logic [8:0] inner;
    logic [8:0] bank;
    outer = {b, 1'b0};
    if (m[0]) return {6'd0, a};
    if (m[6]) return {outer[8:3], a};
    mk    = m[4] ? 9'h01F : (m[5] ? 9'h07F : 9'h0FF);
    inner = {1'b0, regs[a[12:10]*8 +: 8]};
    bank  = (inner & mk) | (outer & ~mk);
    return {bank, a[9:0]};
  endfunction

  task automatic check(input string req, input logic [18:0] act_a, input logic [18:0] exp_a,
                       input logic act_r, input logic exp_r);
    checks++;
    if (act_a !== exp_a || act_r !== exp_r) begin
      errors++;
      $display("FAIL %s: addr=%h sel=%0b expected addr=%h sel=%0b", req, act_a, act_r, exp_a, exp_r);
    end
  endtask

  // Drive on the falling edge, let one rising edge register, sample on the next falling edge.
  task automatic apply_and_check(input string req, input logic [7:0] m, input logic [7:0] b,
                                 input logic [63:0] regs, input logic [12:0] a);
    cfg_mode_i  = m;
    cfg_base_i  = b;
    bank_regs_i = regs;
    ppu_addr_i  = a;
    @(posedge clk_i);
    @(negedge clk_i);
    check(req, phys_addr_o, exp_addr(m, b, regs, a), ram_sel_o, m[0]);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    rst_i = 1'b1;
    cfg_mode_i = 8'h01; cfg_base_i = 8'hFF; bank_regs_i = '1; ppu_addr_i = 13'h1FFF;
    @(posedge clk_i);
    @(negedge clk_i);
    check("R1", phys_addr_o, 19'd0, ram_sel_o, 1'b0);
    @(posedge clk_i);
    @(negedge clk_i);
    check("R1", phys_addr_o, 19'd0, ram_sel_o, 1'b0);
    rst_i = 1'b0;
  endtask

  task automatic t_ram_mode;
    apply_and_check("R3", 8'h01, 8'hA5, 64'hFEDC_BA98_7654_3210, 13'h1ABC);
    apply_and_check("R3", 8'h71, 8'hFF, '1, 13'h1FFF);
    apply_and_check("R3", 8'hC1, 8'h3C, 64'h1111_2222_3333_4444, 13'h0000);
  endtask

  task automatic t_wide_bank;
    apply_and_check("R4 R5 R8", 8'h40, 8'hB5, 64'h0123_4567_89AB_CDEF, 13'h1234);
    // R9: the bank registers and the mask bits must not move the result.
    apply_and_check("R9", 8'h70, 8'hB5, 64'hFFFF_0000_FFFF_0000, 13'h1234);
    apply_and_check("R9", 8'h60, 8'hB5, '0, 13'h1234);
    apply_and_check("R4", 8'h40, 8'hFC, '1, 13'h0801);
  endtask

  task automatic t_masks;
    logic [63:0] regs;
    regs = 64'h8F_6E_5D_4C_3B_2A_19_E7;
    apply_and_check("R6 R7 full mask", 8'h00, 8'hFF, regs, 13'h0155);
    apply_and_check("R6 R7 mid mask", 8'h20, 8'hFF, regs, 13'h0555);
    apply_and_check("R6 R7 small mask", 8'h10, 8'hFF, regs, 13'h1155);
    apply_and_check("R6 small over mid", 8'h30, 8'hFF, regs, 13'h1D55);
    apply_and_check("R5 R7 zero base", 8'h20, 8'h00, regs, 13'h1F00);
  endtask

  task automatic t_slots;
    logic [63:0] regs;
    regs = 64'hF1_E2_D3_C4_B5_A6_97_88;
    for (int s = 0; s < 8; s++) begin
      apply_and_check("R7 slot walk", 8'h00, 8'h80, regs, {s[2:0], 10'h2AA});
    end
  endtask

  task automatic t_latency;
    logic [18:0] held_a;
    logic        held_r;
    apply_and_check("R2 setup", 8'h01, 8'h00, '0, 13'h0123);
    held_a = phys_addr_o;
    held_r = ram_sel_o;
    cfg_mode_i = 8'h40; cfg_base_i = 8'hFF; ppu_addr_i = 13'h1FFF;
    #2;
    check("R2 hold", phys_addr_o, held_a, ram_sel_o, held_r);
    @(posedge clk_i);
    @(negedge clk_i);
    check("R2 update", phys_addr_o, exp_addr(8'h40, 8'hFF, '0, 13'h1FFF), ram_sel_o, 1'b0);
  endtask

  initial begin
    t_reset();
    t_ram_mode();
    t_wide_bank();
    t_masks();
    t_slots();
    t_latency();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: addr=%h expected completion", phys_addr_o);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule